// File: doc/BRIEF.md
# Translation Request Merger

This block sits between the agents that need address translations and a TLB. Each incoming request carries a virtual address, a requester ID and an issue time stamp. The time stamp is divided by a window length to give a group number. Requests in the same 4 KiB virtual page and the same group share one table entry, so only a single TLB lookup is issued for them. A control input can turn merging off, and then each request gets its own entry and its own lookup.

Pending entries queue for lookup in allocation order. The TLB side has several lookup lanes, which caps how many lookups leave in one cycle. A lookup the TLB refuses stays at the head of the queue and is offered again on the next cycle. Its tag is the entry index, and the TLB returns that tag with the physical frame number. The block then sends one response per requester of that entry, one per cycle, and each response holds the returned frame joined to that requester's own page offset. A finished entry is not released in the same cycle. Its index goes into a cleanup queue, and the entry is freed one cycle later. Two counters report the number of accepted requests and the number of lookups sent.

Top module: `tlb_coalescer`

## Requirements
- R1: The virtual page number is req_va[VA_W-1:12]. A lookup lane shows the page number of its entry on lk_vpn and the entry index on lk_tag. Only requests with equal page numbers can share an entry.
- R2: The group of a request is req_stamp / WIN (integer division). Requests merge only when their groups are equal. A request of the same page in a different group gets its own entry and its own lookup.
- R3: At most N_LK lookups leave per cycle. Lane k is valid only if it has a queued entry and every lane below k completes its handshake in the same cycle. Entries beyond the lanes that fire wait for a later cycle.
- R4: While coal_off is 1, no request merges. Two requests to the same page in the same group produce two lookups.
- R5: tr_ready is 1 exactly when no delivery is in progress. An accepted TLB response starts the delivery for the entry named by tr_tag.
- R6: A lookup refused on lane 0 stays valid on lane 0 with the same page number until it is accepted. Lookups leave in the order their entries were allocated.
- R7: Each requester of an entry receives one response. rsp_id is its ID and rsp_pa = {tr_pfn, its own req_va[11:0]}. Responses come in arrival order, one per handshake, and a new one can follow on every cycle.
- R8: An entry is freed one cycle after its last response handshake, not in the same cycle. With the table full, req_ready for a new page stays 0 in the cycle right after that handshake and becomes 1 in the cycle after that.
- R9: cnt_lk counts lookup handshakes on all lanes.
- R10: cnt_in counts accepted requests (req_valid and req_ready both 1).
- R11: req_ready is 0 when the request would merge into an entry that already holds N_WAIT requesters, or when it needs a new entry and none is free. A request to another page with a free entry is still accepted.
- R12: After reset, lk_valid, rsp_valid, cnt_in and cnt_lk are all 0, and req_ready and tr_ready are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| coal_off | input | 1 | 1 disables merging |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted when valid |
| req_va | input | VA_W | Virtual address |
| req_id | input | ID_W | Requester ID |
| req_stamp | input | TS_W | Issue time stamp |
| lk_valid | output | N_LK | Per-lane lookup valid |
| lk_ready | input | N_LK | Per-lane lookup ready |
| lk_vpn | output | N_LK x (VA_W-12) | Per-lane virtual page number |
| lk_tag | output | N_LK x log2(N_ENT) | Per-lane entry tag |
| tr_valid | input | 1 | TLB response valid |
| tr_ready | output | 1 | TLB response accepted |
| tr_tag | input | log2(N_ENT) | Tag of the answered lookup |
| tr_pfn | input | PA_W-12 | Returned physical frame number |
| rsp_valid | output | 1 | Response to a requester valid |
| rsp_ready | input | 1 | Response accepted |
| rsp_id | output | ID_W | Requester ID of the response |
| rsp_pa | output | PA_W | Physical address |
| cnt_in | output | CNT_W | Accepted request count |
| cnt_lk | output | CNT_W | Lookups sent count |

## Verification
The assertions assume a well-behaved environment. The TLB only answers tags that it has accepted as lookups and whose answers are still open, and it raises tr_valid only while tr_ready is 1. The output-side checks take for granted that the counters do not wrap inside one window of observation. The bench stays within these limits. It answers only tags it has read from lk_tag, drives tr_valid for one cycle and only when idle, and makes far fewer handshakes than the counter range. All inputs are changed on the falling edge.

// File: rtl/coal_pkg.sv
package coal_pkg;
    // 4 KiB pages: low address bits are the in-page offset
    localparam int PG_OFF_W = 12;
endpackage

// File: rtl/coal_idx_fifo.sv
// Small index queue: one push per cycle, up to NPOP pops per cycle,
// the first NPOP entries visible at once. DEPTH must be a power of two >= 2.
module coal_idx_fifo #(
    parameter int DEPTH = 4,
    parameter int W     = 2,
    parameter int NPOP  = 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    push,
    input  logic [W-1:0]            push_data,
    input  logic [$clog2(NPOP+1)-1:0] pop_n,
    output logic [$clog2(DEPTH+1)-1:0] count,
    output logic [NPOP-1:0][W-1:0]  peek
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH+1);

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [AW-1:0]           rd;
        logic [AW-1:0]           wr;
        logic [CW-1:0]           cnt;
    } fq_t;

    fq_t f_q, f_d;

    for (genvar k = 0; k < NPOP; k++) begin : g_peek
        assign peek[k] = f_q.mem[f_q.rd + AW'(k)];
    end

    assign count = f_q.cnt;

    always_comb begin
        f_d = f_q;
        if (push) begin
            f_d.mem[f_q.wr] = push_data;
            f_d.wr          = f_q.wr + AW'(1);
        end
        f_d.rd  = f_q.rd + AW'(pop_n);
        f_d.cnt = f_q.cnt + CW'(push) - CW'(pop_n);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) f_q <= '0;
        else        f_q <= f_d;
    end
endmodule

// File: rtl/coal_match.sv
// Finds the open entry a request can join, and the lowest free entry.
module coal_match #(
    parameter int N     = 4,
    parameter int VPN_W = 20,
    parameter int G_W   = 16,
    parameter int EI_W  = 2
) (
    input  logic                     en,
    input  logic [VPN_W-1:0]         key_vpn,
    input  logic [G_W-1:0]           key_grp,
    input  logic [N-1:0]             ent_vld,
    input  logic [N-1:0]             ent_open,
    input  logic [N-1:0]             ent_full,
    input  logic [N-1:0][VPN_W-1:0]  ent_vpn,
    input  logic [N-1:0][G_W-1:0]    ent_grp,
    output logic                     hit,
    output logic [EI_W-1:0]          hit_idx,
    output logic                     hit_full,
    output logic                     free_ok,
    output logic [EI_W-1:0]          free_idx
);
    logic [N-1:0] same;

    for (genvar i = 0; i < N; i++) begin : g_cmp
        assign same[i] = en && ent_open[i] &&
                         (ent_vpn[i] == key_vpn) && (ent_grp[i] == key_grp);
    end

    always_comb begin
        hit      = 1'b0;
        hit_idx  = '0;
        hit_full = 1'b0;
        free_ok  = 1'b0;
        free_idx = '0;
        for (int i = N-1; i >= 0; i--) begin
            if (same[i]) begin
                hit      = 1'b1;
                hit_idx  = EI_W'(i);
                hit_full = ent_full[i];
            end
            if (!ent_vld[i]) begin
                free_ok  = 1'b1;
                free_idx = EI_W'(i);
            end
        end
    end
endmodule

// File: rtl/tlb_coalescer.sv
module tlb_coalescer
    import coal_pkg::*;
#(
    parameter int VA_W   = 32,
    parameter int PA_W   = 32,
    parameter int ID_W   = 4,
    parameter int TS_W   = 16,
    parameter int WIN    = 1,
    parameter int N_LK   = 2,
    parameter int N_ENT  = 4,
    parameter int N_WAIT = 4,
    parameter int CNT_W  = 16
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic                                   coal_off,
    input  logic                                   req_valid,
    output logic                                   req_ready,
    input  logic [VA_W-1:0]                        req_va,
    input  logic [ID_W-1:0]                        req_id,
    input  logic [TS_W-1:0]                        req_stamp,
    output logic [N_LK-1:0]                        lk_valid,
    input  logic [N_LK-1:0]                        lk_ready,
    output logic [N_LK-1:0][VA_W-PG_OFF_W-1:0]     lk_vpn,
    output logic [N_LK-1:0][$clog2(N_ENT)-1:0]     lk_tag,
    input  logic                                   tr_valid,
    output logic                                   tr_ready,
    input  logic [$clog2(N_ENT)-1:0]               tr_tag,
    input  logic [PA_W-PG_OFF_W-1:0]               tr_pfn,
    output logic                                   rsp_valid,
    input  logic                                   rsp_ready,
    output logic [ID_W-1:0]                        rsp_id,
    output logic [PA_W-1:0]                        rsp_pa,
    output logic [CNT_W-1:0]                       cnt_in,
    output logic [CNT_W-1:0]                       cnt_lk
);
    localparam int VPN_W = VA_W - PG_OFF_W;
    localparam int PFN_W = PA_W - PG_OFF_W;
    localparam int EI_W  = $clog2(N_ENT);
    localparam int CW    = $clog2(N_WAIT + 1);
    localparam int WI_W  = (N_WAIT > 1) ? $clog2(N_WAIT) : 1;
    localparam int LW    = $clog2(N_LK + 1);
    localparam int QC_W  = $clog2(N_ENT + 1);

    typedef struct packed {
        logic                               vld;
        logic                               done;
        logic [VPN_W-1:0]                   vpn;
        logic [TS_W-1:0]                    grp;
        logic [PFN_W-1:0]                   pfn;
        logic [CW-1:0]                      cnt;
        logic [N_WAIT-1:0][ID_W-1:0]        ids;
        logic [N_WAIT-1:0][PG_OFF_W-1:0]    offs;
    } ent_t;

    typedef struct packed {
        ent_t [N_ENT-1:0]  ent;
        logic              dl_busy;
        logic [EI_W-1:0]   dl_ent;
        logic [WI_W-1:0]   dl_ptr;
        logic [CNT_W-1:0]  cnt_in;
        logic [CNT_W-1:0]  cnt_lk;
    } st_t;

    st_t s_q, s_d;

    // table views for the matcher
    logic [N_ENT-1:0]             ent_vld, ent_open, ent_full;
    logic [N_ENT-1:0][VPN_W-1:0]  ent_vpn;
    logic [N_ENT-1:0][TS_W-1:0]   ent_grp;

    for (genvar i = 0; i < N_ENT; i++) begin : g_view
        assign ent_vld[i]  = s_q.ent[i].vld;
        assign ent_open[i] = s_q.ent[i].vld && !s_q.ent[i].done;
        assign ent_full[i] = (s_q.ent[i].cnt == CW'(N_WAIT));
        assign ent_vpn[i]  = s_q.ent[i].vpn;
        assign ent_grp[i]  = s_q.ent[i].grp;
    end

    logic [VPN_W-1:0] key_vpn;
    logic [TS_W-1:0]  key_grp;
    logic             hit, hit_full, free_ok;
    logic [EI_W-1:0]  hit_idx, free_idx;

    assign key_vpn = req_va[VA_W-1:PG_OFF_W];
    assign key_grp = req_stamp / TS_W'(WIN);

    coal_match #(
        .N(N_ENT), .VPN_W(VPN_W), .G_W(TS_W), .EI_W(EI_W)
    ) u_match (
        .en       (!coal_off),
        .key_vpn  (key_vpn),
        .key_grp  (key_grp),
        .ent_vld  (ent_vld),
        .ent_open (ent_open),
        .ent_full (ent_full),
        .ent_vpn  (ent_vpn),
        .ent_grp  (ent_grp),
        .hit      (hit),
        .hit_idx  (hit_idx),
        .hit_full (hit_full),
        .free_ok  (free_ok),
        .free_idx (free_idx)
    );

    assign req_ready = hit ? !hit_full : free_ok;

    // issue queue: entry indices in allocation order
    logic                        iq_push;
    logic [LW-1:0]               pop_n;
    logic [QC_W-1:0]             iq_cnt;
    logic [N_LK-1:0][EI_W-1:0]   iq_peek;

    assign iq_push = req_valid && req_ready && !hit;

    coal_idx_fifo #(.DEPTH(N_ENT), .W(EI_W), .NPOP(N_LK)) u_issue_q (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (iq_push),
        .push_data (free_idx),
        .pop_n     (pop_n),
        .count     (iq_cnt),
        .peek      (iq_peek)
    );

    // cleanup queue: entries whose responses are all delivered
    logic                 cq_push, cq_pop;
    logic [EI_W-1:0]      cq_data;
    logic [QC_W-1:0]      cq_cnt;
    logic [0:0][EI_W-1:0] cq_peek;

    coal_idx_fifo #(.DEPTH(N_ENT), .W(EI_W), .NPOP(1)) u_clean_q (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (cq_push),
        .push_data (cq_data),
        .pop_n     (cq_pop),
        .count     (cq_cnt),
        .peek      (cq_peek)
    );

    // lookup lanes: lane k goes only if every lane below it goes
    logic [N_LK-1:0] lk_fire;
    logic            prev_ok;

    always_comb begin
        lk_valid = '0;
        lk_fire  = '0;
        pop_n    = '0;
        prev_ok  = 1'b1;
        for (int k = 0; k < N_LK; k++) begin
            lk_valid[k] = (k < int'(iq_cnt)) && prev_ok;
            lk_fire[k]  = lk_valid[k] && lk_ready[k];
            prev_ok     = lk_fire[k];
            pop_n       = pop_n + LW'(lk_fire[k]);
        end
    end

    for (genvar k = 0; k < N_LK; k++) begin : g_lane
        assign lk_tag[k] = iq_peek[k];
        assign lk_vpn[k] = s_q.ent[iq_peek[k]].vpn;
    end

    // delivery outputs
    assign tr_ready  = !s_q.dl_busy;
    assign rsp_valid = s_q.dl_busy;
    assign rsp_id    = s_q.ent[s_q.dl_ent].ids[s_q.dl_ptr];
    assign rsp_pa    = {s_q.ent[s_q.dl_ent].pfn, s_q.ent[s_q.dl_ent].offs[s_q.dl_ptr]};
    assign cnt_in    = s_q.cnt_in;
    assign cnt_lk    = s_q.cnt_lk;

    logic [WI_W-1:0] slot;
    logic            last_rsp;

    always_comb begin
        s_d      = s_q;
        cq_push  = 1'b0;
        cq_pop   = 1'b0;
        cq_data  = s_q.dl_ent;
        slot     = s_q.ent[hit_idx].cnt[WI_W-1:0];
        last_rsp = ((CW'(s_q.dl_ptr) + CW'(1)) == s_q.ent[s_q.dl_ent].cnt);

        // deferred release of a finished entry
        if (cq_cnt != '0) begin
            cq_pop                   = 1'b1;
            s_d.ent[cq_peek[0]].vld  = 1'b0;
        end

        // translation returned: store frame, close entry, start delivery
        if (tr_valid && tr_ready) begin
            s_d.ent[tr_tag].pfn  = tr_pfn;
            s_d.ent[tr_tag].done = 1'b1;
            s_d.dl_busy          = 1'b1;
            s_d.dl_ent           = tr_tag;
            s_d.dl_ptr           = '0;
        end

        // one requester answered per handshake
        if (rsp_valid && rsp_ready) begin
            if (last_rsp) begin
                s_d.dl_busy = 1'b0;
                cq_push     = 1'b1;
            end else begin
                s_d.dl_ptr  = s_q.dl_ptr + WI_W'(1);
            end
        end

        // incoming request: join an open entry or allocate a new one
        if (req_valid && req_ready) begin
            if (hit) begin
                s_d.ent[hit_idx].ids[slot]  = req_id;
                s_d.ent[hit_idx].offs[slot] = req_va[PG_OFF_W-1:0];
                s_d.ent[hit_idx].cnt        = s_q.ent[hit_idx].cnt + CW'(1);
            end else begin
                s_d.ent[free_idx].vld     = 1'b1;
                s_d.ent[free_idx].done    = 1'b0;
                s_d.ent[free_idx].vpn     = key_vpn;
                s_d.ent[free_idx].grp     = key_grp;
                s_d.ent[free_idx].pfn     = '0;
                s_d.ent[free_idx].cnt     = CW'(1);
                s_d.ent[free_idx].ids     = '0;
                s_d.ent[free_idx].offs    = '0;
                s_d.ent[free_idx].ids[0]  = req_id;
                s_d.ent[free_idx].offs[0] = req_va[PG_OFF_W-1:0];
            end
            s_d.cnt_in = s_q.cnt_in + CNT_W'(1);
        end

        s_d.cnt_lk = s_q.cnt_lk + CNT_W'(pop_n);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end
endmodule

// File: rtl/coal_chk.sv
module coal_chk #(
    parameter int N_LK  = 2,
    parameter int VPN_W = 20,
    parameter int ID_W  = 4,
    parameter int PA_W  = 32,
    parameter int CNT_W = 16
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         req_valid,
    input logic                         req_ready,
    input logic [N_LK-1:0]              lk_valid,
    input logic [N_LK-1:0]              lk_ready,
    input logic [N_LK-1:0][VPN_W-1:0]   lk_vpn,
    input logic                         tr_ready,
    input logic                         rsp_valid,
    input logic                         rsp_ready,
    input logic [ID_W-1:0]              rsp_id,
    input logic [PA_W-1:0]              rsp_pa,
    input logic [CNT_W-1:0]             cnt_in,
    input logic [CNT_W-1:0]             cnt_lk
);
    AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_id) && $stable(rsp_pa)); // R7

    AST_LK_RETRY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid[0] && !lk_ready[0] |=> lk_valid[0] && $stable(lk_vpn[0])); // R6

    AST_ONE_DELIVERY: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !tr_ready); // R5

    AST_IN_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready |=> cnt_in != $past(cnt_in)); // R10

    AST_LK_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid[0] && lk_ready[0] |=> cnt_lk != $past(cnt_lk)); // R9
endmodule

bind tlb_coalescer coal_chk #(
    .N_LK(N_LK), .VPN_W(VPN_W), .ID_W(ID_W), .PA_W(PA_W), .CNT_W(CNT_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .lk_valid  (lk_valid),
    .lk_ready  (lk_ready),
    .lk_vpn    (lk_vpn),
    .tr_ready  (tr_ready),
    .rsp_valid (rsp_valid),
    .rsp_ready (rsp_ready),
    .rsp_id    (rsp_id),
    .rsp_pa    (rsp_pa),
    .cnt_in    (cnt_in),
    .cnt_lk    (cnt_lk)
);

// File: tb/sim_tlb_coalescer.sv
`timescale 1ns/1ps
module sim_tlb_coalescer;
    localparam int VA_W = 32, PA_W = 32, ID_W = 4, TS_W = 16, WIN = 4;
    localparam int N_LK = 2, N_ENT = 4, N_WAIT = 2, CNT_W = 16;
    localparam int VPN_W = VA_W - 12, PFN_W = PA_W - 12, EI_W = 2;

    logic clk = 1'b0, rst_n = 1'b0, coal_off = 1'b0;
    logic req_valid = 1'b0, req_ready;
    logic [VA_W-1:0] req_va = '0;
    logic [ID_W-1:0] req_id = '0;
    logic [TS_W-1:0] req_stamp = '0;
    logic [N_LK-1:0] lk_valid, lk_ready = '0;
    logic [N_LK-1:0][VPN_W-1:0] lk_vpn;
    logic [N_LK-1:0][EI_W-1:0]  lk_tag;
    logic tr_valid = 1'b0, tr_ready;
    logic [EI_W-1:0] tr_tag = '0;
    logic [PFN_W-1:0] tr_pfn = '0;
    logic rsp_valid, rsp_ready = 1'b0;
    logic [ID_W-1:0] rsp_id;
    logic [PA_W-1:0] rsp_pa;
    logic [CNT_W-1:0] cnt_in, cnt_lk;

    always #5 clk = ~clk;

    tlb_coalescer #(
        .VA_W(VA_W), .PA_W(PA_W), .ID_W(ID_W), .TS_W(TS_W), .WIN(WIN),
        .N_LK(N_LK), .N_ENT(N_ENT), .N_WAIT(N_WAIT), .CNT_W(CNT_W)
    ) u0 (.*);

    int n_chk = 0, n_bad = 0, n_in = 0, n_lk = 0;
    bit finished = 1'b0;

    localparam int NV = 5;
    localparam logic [31:0] V_VA  [NV] = '{32'h0000_1000, 32'hFFFF_FFFF, 32'h8000_0ABC, 32'h0ABC_D123, 32'h7654_3000};
    localparam logic [19:0] V_PFN [NV] = '{20'h00001, 20'h12345, 20'h00000, 20'hFEDCB, 20'h0F0F0};
    localparam logic [31:0] V_PA  [NV] = '{32'h0000_1000, 32'h1234_5FFF, 32'h0000_0ABC, 32'hFEDC_B123, 32'h0F0F_0000};

    task automatic chk(input bit ok, input string rq, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s act=%0h exp=%0h", rq, act, exp);
        end
    endtask

    task automatic send_req(input logic [31:0] va, input logic [3:0] id, input logic [15:0] st);
        req_va = va; req_id = id; req_stamp = st; req_valid = 1'b1;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        n_in++;
    endtask

    task automatic take_one(input logic [19:0] vpn, input string rq, output logic [1:0] tag);
        chk(lk_valid[0] === 1'b1, rq, 64'(lk_valid[0]), 64'd1);
        chk(lk_vpn[0] === vpn, rq, 64'(lk_vpn[0]), 64'(vpn));
        tag = lk_tag[0];
        lk_ready = 2'b01;
        @(negedge clk);
        lk_ready = 2'b00;
        n_lk++;
    endtask

    task automatic take_two(input logic [19:0] v0, input logic [19:0] v1, input string rq,
                            output logic [1:0] t0, output logic [1:0] t1);
        lk_ready = 2'b11;
        #1;
        chk(lk_valid === 2'b11, rq, 64'(lk_valid), 64'd3);
        chk(lk_vpn[0] === v0 && lk_vpn[1] === v1, rq, 64'({lk_vpn[0], lk_vpn[1]}), 64'({v0, v1}));
        t0 = lk_tag[0]; t1 = lk_tag[1];
        @(negedge clk);
        lk_ready = 2'b00;
        n_lk += 2;
    endtask

    task automatic give_tr(input logic [1:0] tag, input logic [19:0] pfn);
        chk(tr_ready === 1'b1, "R5", 64'(tr_ready), 64'd1);
        tr_tag = tag; tr_pfn = pfn; tr_valid = 1'b1;
        @(negedge clk);
        tr_valid = 1'b0;
        chk(tr_ready === 1'b0, "R5", 64'(tr_ready), 64'd0);
    endtask

    task automatic exp_rsp(input logic [3:0] id, input logic [31:0] pa);
        chk(rsp_valid === 1'b1, "R7", 64'(rsp_valid), 64'd1);
        chk(rsp_id === id && rsp_pa === pa, "R7", 64'({rsp_id, rsp_pa}), 64'({id, pa}));
        rsp_ready = 1'b1;
        @(negedge clk);
        rsp_ready = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog act=hung exp=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [1:0] t0, t1, t2, t3;
        repeat (3) @(negedge clk);
        // R12: reset state
        chk(lk_valid === 2'b00 && rsp_valid === 1'b0, "R12", 64'({lk_valid, rsp_valid}), 64'd0);
        chk(cnt_in === '0 && cnt_lk === '0, "R12", 64'({cnt_in, cnt_lk}), 64'd0);
        chk(req_ready === 1'b1 && tr_ready === 1'b1, "R12", 64'({req_ready, tr_ready}), 64'd3);
        rst_n = 1'b1;
        @(negedge clk);

        // table walk: single requests, page split (R1) and address rebuild (R7)
        for (int v = 0; v < NV; v++) begin
            send_req(V_VA[v], 4'(v + 1), 16'(v * 4));
            take_one(V_VA[v][31:12], "R1", t0);
            give_tr(t0, V_PFN[v]);
            exp_rsp(4'(v + 1), V_PA[v]);
            repeat (2) @(negedge clk);
        end

        // R2: stamps 4 and 7 share group 1 -> one lookup, two responses in order
        send_req(32'h1234_5010, 4'd1, 16'd4);
        send_req(32'h1234_5ABC, 4'd2, 16'd7);
        take_one(20'h12345, "R2", t0);
        chk(lk_valid === 2'b00, "R2", 64'(lk_valid), 64'd0);
        give_tr(t0, 20'h0ABCD);
        exp_rsp(4'd1, 32'h0ABC_D010);
        exp_rsp(4'd2, 32'h0ABC_DABC);
        chk(cnt_lk === CNT_W'(n_lk), "R9", 64'(cnt_lk), 64'(n_lk));
        repeat (2) @(negedge clk);

        // R2: stamps 7 and 8 fall in different groups -> two lookups
        send_req(32'h2222_2001, 4'd3, 16'd7);
        send_req(32'h2222_2002, 4'd4, 16'd8);
        take_two(20'h22222, 20'h22222, "R2", t0, t1);
        chk(lk_valid === 2'b00, "R2", 64'(lk_valid), 64'd0);
        give_tr(t0, 20'h00111);
        exp_rsp(4'd3, 32'h0011_1001);
        give_tr(t1, 20'h00222);
        exp_rsp(4'd4, 32'h0022_2002);
        repeat (2) @(negedge clk);

        // R3: three pending lookups, two lanes -> two now, one next cycle
        send_req(32'h0000_A00E, 4'd5, 16'd0);
        send_req(32'h0000_B00F, 4'd6, 16'd0);
        send_req(32'h0000_C010, 4'd7, 16'd0);
        take_two(20'h0000A, 20'h0000B, "R3", t0, t1);
        take_one(20'h0000C, "R3", t2);
        give_tr(t0, 20'h00AAA); exp_rsp(4'd5, 32'h00AA_A00E);
        give_tr(t1, 20'h00BBB); exp_rsp(4'd6, 32'h00BB_B00F);
        give_tr(t2, 20'h00CCC); exp_rsp(4'd7, 32'h00CC_C010);
        repeat (2) @(negedge clk);

        // R6: lane 0 refused, lane 1 ready -> lane 1 held back; lane 0 stable
        send_req(32'h0000_D000, 4'd8, 16'd0);
        send_req(32'h0000_E000, 4'd9, 16'd0);
        lk_ready = 2'b10;
        #1;
        chk(lk_valid === 2'b01, "R6", 64'(lk_valid), 64'd1);
        @(negedge clk);
        chk(lk_valid[0] === 1'b1 && lk_vpn[0] === 20'h0000D, "R6", 64'(lk_vpn[0]), 64'h0000D);
        @(negedge clk);
        chk(lk_vpn[0] === 20'h0000D, "R6", 64'(lk_vpn[0]), 64'h0000D);
        take_two(20'h0000D, 20'h0000E, "R6", t0, t1);
        give_tr(t0, 20'h0D0D0); exp_rsp(4'd8, 32'h0D0D_0000);
        give_tr(t1, 20'h0E0E0); exp_rsp(4'd9, 32'h0E0E_0000);
        repeat (2) @(negedge clk);

        // R4: merging disabled -> same page and group gives two lookups
        coal_off = 1'b1;
        send_req(32'h3333_3004, 4'd10, 16'd1);
        send_req(32'h3333_3008, 4'd11, 16'd2);
        take_two(20'h33333, 20'h33333, "R4", t0, t1);
        coal_off = 1'b0;
        give_tr(t0, 20'h00044); exp_rsp(4'd10, 32'h0004_4004);
        give_tr(t1, 20'h00088); exp_rsp(4'd11, 32'h0008_8008);
        repeat (2) @(negedge clk);

        // R11: entry with N_WAIT requesters stalls its page, not others
        send_req(32'h4444_4001, 4'd12, 16'd0);
        send_req(32'h4444_4002, 4'd13, 16'd1);
        req_va = 32'h4444_4003; req_stamp = 16'd2;
        #1;
        chk(req_ready === 1'b0, "R11", 64'(req_ready), 64'd0);
        req_va = 32'h5555_5003;
        #1;
        chk(req_ready === 1'b1, "R11", 64'(req_ready), 64'd1);
        take_one(20'h44444, "R11", t0);
        give_tr(t0, 20'h00404);
        exp_rsp(4'd12, 32'h0040_4001);
        exp_rsp(4'd13, 32'h0040_4002);
        repeat (2) @(negedge clk);

        // R11/R8: table full stalls; release is one cycle after last response
        send_req(32'h0001_0001, 4'd1, 16'd0);
        send_req(32'h0002_0002, 4'd2, 16'd0);
        send_req(32'h0003_0003, 4'd3, 16'd0);
        send_req(32'h0004_0004, 4'd4, 16'd0);
        req_va = 32'h0005_0005; req_stamp = 16'd0;
        #1;
        chk(req_ready === 1'b0, "R11", 64'(req_ready), 64'd0);
        take_two(20'h00010, 20'h00020, "R3", t0, t1);
        take_two(20'h00030, 20'h00040, "R3", t2, t3);
        give_tr(t0, 20'h00F01);
        exp_rsp(4'd1, 32'h00F0_1001);
        chk(req_ready === 1'b0, "R8", 64'(req_ready), 64'd0);
        @(negedge clk);
        chk(req_ready === 1'b1, "R8", 64'(req_ready), 64'd1);
        give_tr(t1, 20'h00F02); exp_rsp(4'd2, 32'h00F0_2002);
        give_tr(t2, 20'h00F03); exp_rsp(4'd3, 32'h00F0_3003);
        give_tr(t3, 20'h00F04); exp_rsp(4'd4, 32'h00F0_4004);
        repeat (2) @(negedge clk);

        chk(cnt_in === CNT_W'(n_in), "R10", 64'(cnt_in), 64'(n_in));
        chk(cnt_lk === CNT_W'(n_lk), "R9", 64'(cnt_lk), 64'(n_lk));
        chk(rsp_valid === 1'b0 && lk_valid === 2'b00, "R7", 64'({rsp_valid, lk_valid}), 64'd0);

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule